// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel-RGB (TFT-style) panel from a single pixel clock. Two wrapping counters walk through every pixel position of a frame. From those positions it derives horizontal sync, vertical sync, a data-valid strobe, and horizontal and vertical blanking status. It also reports the pixel and line coordinates inside the visible area, which a pixel-fetch stage uses to address its frame store.

Every timing value is a run-time input. These are the frame totals, the visible size, and where the visible window starts. They also include where the data strobe starts, and the start offset and length of each sync pulse. All horizontal offsets count from the first clock of a line, and every line begins in horizontal blanking. All vertical offsets count from the first line of a frame, and every frame begins in vertical blanking. The timing values are captured at reset and at the end of each frame, so a change made while a frame is being drawn cannot tear it.

Each panel strobe has its own polarity and its own enable. A master pad enable sits above all of them and also gates the forwarded panel clock, whose phase is selectable. Blanking status feeds two sticky flags, which combine with their enables into one interrupt line.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is high, every registered output (syncs, data strobe, blanking status, coordinates, flags) is 0 after the next clock edge, and the timing inputs present then are captured as the working setup.
- R2: The position (h, v) starts at (0, 0) after reset. h advances every clock and wraps to 0 after h = total width − 1. v advances when h wraps and wraps to 0 after v = total height − 1. The outputs for position k appear after the (k+1)-th clock edge following reset. pix_x_o = h − active start pixel and line_y_o = v − active start line inside the visible window, and both are 0 elsewhere.
- R3: hblank_o is 1 unless h lies in [active start pixel, active start pixel + active width). vblank_o is 1 unless v lies in [active start line, active start line + active height). Neither is gated by any enable.
- R4: The raw horizontal sync is active for h in [hsync start, hsync start + L), where L is the pulse length and a length of 0 is treated as 1.
- R5: The raw vertical sync is active for whole lines v in [vsync start, vsync start + L), where a length of 0 is treated as 1.
- R6: The raw data strobe is active when h lies in [data start pixel, data start pixel + active width) and v lies in [data start line, data start line + active height). These windows are independent of the visible window.
- R7: The polarity bit of each strobe selects its level. With polarity 1 the pin is high while the strobe is active. With polarity 0 the pin is low while the strobe is active.
- R8: A strobe whose own enable is 0 drives a constant 0.
- R9: While pad_en is 0, hsync_o, vsync_o, de_o and pclk_o are all 0.
- R10: Each blanking flag is set in every cycle its blanking status is 1. A flag is cleared by its clear input only when blanking is not being set in the same cycle, and otherwise holds. irq_o = (hblank flag AND its enable) OR (vblank flag AND its enable).
- R11: pclk_o = pad_en AND (clk XOR clk_pol). With clk_pol = 1 the forwarded clock is inverted, so the panel's rising edge falls in the middle of each data cycle.
- R12: Timing inputs changed during a frame take effect only from position (0, 0) of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_total | input | 11 | Clocks per line |
| cfg_v_total | input | 11 | Lines per frame |
| cfg_h_active | input | 11 | Visible pixels per line |
| cfg_v_active | input | 11 | Visible lines per frame |
| cfg_h_act_ofs | input | 8 | First visible pixel, counted from line start |
| cfg_v_act_ofs | input | 8 | First visible line, counted from frame start |
| cfg_h_de_ofs | input | 8 | First data-strobe clock in a line |
| cfg_v_de_ofs | input | 8 | First data-strobe line in a frame |
| cfg_hs_ofs | input | 8 | Horizontal sync start clock |
| cfg_hs_len | input | 8 | Horizontal sync length in clocks (0 means 1) |
| cfg_vs_ofs | input | 8 | Vertical sync start line |
| cfg_vs_len | input | 8 | Vertical sync length in lines (0 means 1) |
| pol_hs | input | 1 | Horizontal sync polarity, 1 = active high |
| pol_vs | input | 1 | Vertical sync polarity, 1 = active high |
| pol_de | input | 1 | Data strobe polarity, 1 = active high |
| oe_hs | input | 1 | Horizontal sync pin enable |
| oe_vs | input | 1 | Vertical sync pin enable |
| oe_de | input | 1 | Data strobe pin enable |
| pad_en | input | 1 | Master enable for all panel pins |
| clk_pol | input | 1 | Forwarded clock inversion |
| irq_en_h | input | 1 | Interrupt enable for the hblank flag |
| irq_en_v | input | 1 | Interrupt enable for the vblank flag |
| flag_clr_h | input | 1 | Clear pulse for the hblank flag |
| flag_clr_v | input | 1 | Clear pulse for the vblank flag |
| pclk_o | output | 1 | Forwarded panel clock |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data strobe pin |
| hblank_o | output | 1 | Horizontal blanking status |
| vblank_o | output | 1 | Vertical blanking status |
| pix_x_o | output | 11 | Visible pixel coordinate |
| line_y_o | output | 11 | Visible line coordinate |
| hb_flag_o | output | 1 | Sticky hblank flag |
| vb_flag_o | output | 1 | Sticky vblank flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench keeps the package defaults: 11-bit coordinates and 8-bit offsets. It drives small run-time frames of 24×10 and 16×8 so that many complete frames, including frame wrap and the shadow reload, fit in a short run. These sizes let every edge of every window be reached. That covers a sync pulse that starts at position 0, a zero-length pulse, a data window offset from the visible window, and a visible window that shrinks mid-frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CRD_W = 11;
    localparam int OFS_W = 8;
    localparam int NSIG  = 3;

    typedef logic [CRD_W-1:0] crd_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum int {SIG_HS = 0, SIG_VS = 1, SIG_DE = 2} sig_e;

    typedef struct packed {
        crd_t h_total;
        crd_t v_total;
        crd_t h_active;
        crd_t v_active;
        ofs_t h_act_ofs;
        ofs_t v_act_ofs;
        ofs_t h_de_ofs;
        ofs_t v_de_ofs;
        ofs_t hs_ofs;
        ofs_t hs_len;
        ofs_t vs_ofs;
        ofs_t vs_len;
    } tcfg_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic hblank;
        logic vblank;
        crd_t x;
        crd_t y;
    } raw_t;

    function automatic crd_t widen(ofs_t v);
        return crd_t'(v);
    endfunction

    function automatic ofs_t at_least_one(ofs_t v);
        return (v == '0) ? ofs_t'(1) : v;
    endfunction

    function automatic logic in_span(crd_t pos, crd_t start, crd_t len);
        logic [CRD_W:0] stop;
        stop = {1'b0, start} + {1'b0, len};
        return (pos >= start) && ({1'b0, pos} < stop);
    endfunction

endpackage

// File: rtl/dtg_wrap_ctr.sv
module dtg_wrap_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] total,
    output logic [W-1:0] cnt,
    output logic         at_end
);
    localparam logic [W-1:0] ONE = W'(1);

    assign at_end = (cnt >= (total - ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_end ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
(
    input  tcfg_t cfg,
    input  crd_t  h,
    input  crd_t  v,
    output raw_t  raw
);
    logic h_vis, v_vis, h_de, v_de;
    crd_t h_start, v_start;

    always_comb begin
        h_start = widen(cfg.h_act_ofs);
        v_start = widen(cfg.v_act_ofs);
        h_vis   = in_span(h, h_start, cfg.h_active);
        v_vis   = in_span(v, v_start, cfg.v_active);
        h_de    = in_span(h, widen(cfg.h_de_ofs), cfg.h_active);
        v_de    = in_span(v, widen(cfg.v_de_ofs), cfg.v_active);

        raw.hblank = ~h_vis;
        raw.vblank = ~v_vis;
        raw.de     = h_de & v_de;
        raw.hsync  = in_span(h, widen(cfg.hs_ofs), widen(at_least_one(cfg.hs_len)));
        raw.vsync  = in_span(v, widen(cfg.vs_ofs), widen(at_least_one(cfg.vs_len)));
        raw.x      = (h_vis && v_vis) ? (h - h_start) : '0;
        raw.y      = (h_vis && v_vis) ? (v - v_start) : '0;
    end
endmodule

// File: rtl/dtg_pad_stage.sv
module dtg_pad_stage #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pad_en,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] oe,
    output logic [N-1:0] pin
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                pin[i] <= 1'b0;
            end else begin
                pin[i] <= pad_en & oe[i] & ~(raw[i] ^ pol[i]);
            end
        end
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CRD_W-1:0] cfg_h_total,
    input  logic [CRD_W-1:0] cfg_v_total,
    input  logic [CRD_W-1:0] cfg_h_active,
    input  logic [CRD_W-1:0] cfg_v_active,
    input  logic [OFS_W-1:0] cfg_h_act_ofs,
    input  logic [OFS_W-1:0] cfg_v_act_ofs,
    input  logic [OFS_W-1:0] cfg_h_de_ofs,
    input  logic [OFS_W-1:0] cfg_v_de_ofs,
    input  logic [OFS_W-1:0] cfg_hs_ofs,
    input  logic [OFS_W-1:0] cfg_hs_len,
    input  logic [OFS_W-1:0] cfg_vs_ofs,
    input  logic [OFS_W-1:0] cfg_vs_len,
    input  logic             pol_hs,
    input  logic             pol_vs,
    input  logic             pol_de,
    input  logic             oe_hs,
    input  logic             oe_vs,
    input  logic             oe_de,
    input  logic             pad_en,
    input  logic             clk_pol,
    input  logic             irq_en_h,
    input  logic             irq_en_v,
    input  logic             flag_clr_h,
    input  logic             flag_clr_v,
    output logic             pclk_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             hblank_o,
    output logic             vblank_o,
    output logic [CRD_W-1:0] pix_x_o,
    output logic [CRD_W-1:0] line_y_o,
    output logic             hb_flag_o,
    output logic             vb_flag_o,
    output logic             irq_o
);
    tcfg_t live_cfg, work_cfg;
    crd_t  h_pos, v_pos;
    logic  h_end, v_end, frame_last;
    raw_t  raw;
    logic [NSIG-1:0] raw_vec, pol_vec, oe_vec, pin_vec;

    assign live_cfg = '{h_total: cfg_h_total, v_total: cfg_v_total,
                        h_active: cfg_h_active, v_active: cfg_v_active,
                        h_act_ofs: cfg_h_act_ofs, v_act_ofs: cfg_v_act_ofs,
                        h_de_ofs: cfg_h_de_ofs, v_de_ofs: cfg_v_de_ofs,
                        hs_ofs: cfg_hs_ofs, hs_len: cfg_hs_len,
                        vs_ofs: cfg_vs_ofs, vs_len: cfg_vs_len};

    // Working setup: captured in reset and on the last position of a frame
    always_ff @(posedge clk) begin
        if (rst || frame_last) begin
            work_cfg <= live_cfg;
        end
    end

    dtg_wrap_ctr #(.W(CRD_W)) u_hctr (
        .clk(clk), .rst(rst), .step(1'b1),
        .total(work_cfg.h_total), .cnt(h_pos), .at_end(h_end)
    );

    dtg_wrap_ctr #(.W(CRD_W)) u_vctr (
        .clk(clk), .rst(rst), .step(h_end),
        .total(work_cfg.v_total), .cnt(v_pos), .at_end(v_end)
    );

    assign frame_last = h_end & v_end;

    dtg_decode u_dec (
        .cfg(work_cfg), .h(h_pos), .v(v_pos), .raw(raw)
    );

    always_comb begin
        raw_vec = '0;
        pol_vec = '0;
        oe_vec  = '0;
        raw_vec[SIG_HS] = raw.hsync;
        raw_vec[SIG_VS] = raw.vsync;
        raw_vec[SIG_DE] = raw.de;
        pol_vec[SIG_HS] = pol_hs;
        pol_vec[SIG_VS] = pol_vs;
        pol_vec[SIG_DE] = pol_de;
        oe_vec[SIG_HS]  = oe_hs;
        oe_vec[SIG_VS]  = oe_vs;
        oe_vec[SIG_DE]  = oe_de;
    end

    dtg_pad_stage #(.N(NSIG)) u_pads (
        .clk(clk), .rst(rst), .pad_en(pad_en),
        .raw(raw_vec), .pol(pol_vec), .oe(oe_vec), .pin(pin_vec)
    );

    assign hsync_o = pin_vec[SIG_HS];
    assign vsync_o = pin_vec[SIG_VS];
    assign de_o    = pin_vec[SIG_DE];

    always_ff @(posedge clk) begin
        if (rst) begin
            hblank_o  <= 1'b0;
            vblank_o  <= 1'b0;
            pix_x_o   <= '0;
            line_y_o  <= '0;
            hb_flag_o <= 1'b0;
            vb_flag_o <= 1'b0;
        end else begin
            hblank_o  <= raw.hblank;
            vblank_o  <= raw.vblank;
            pix_x_o   <= raw.x;
            line_y_o  <= raw.y;
            hb_flag_o <= (hb_flag_o & ~flag_clr_h) | raw.hblank;
            vb_flag_o <= (vb_flag_o & ~flag_clr_v) | raw.vblank;
        end
    end

    assign irq_o  = (hb_flag_o & irq_en_h) | (vb_flag_o & irq_en_v);
    assign pclk_o = pad_en & (clk ^ clk_pol);
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
    input logic        clk,
    input logic        rst,
    input logic        pad_en,
    input logic        oe_de,
    input logic        flag_clr_h,
    input logic        hsync_o,
    input logic        vsync_o,
    input logic        de_o,
    input logic        hblank_o,
    input logic        vblank_o,
    input logic [10:0] pix_x_o,
    input logic [10:0] line_y_o,
    input logic        hb_flag_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!hsync_o && !vsync_o && !de_o && !hb_flag_o)); // R1

    AST_COORD_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hblank_o || vblank_o) |-> (pix_x_o == '0 && line_y_o == '0)); // R2

    AST_DE_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        !oe_de |=> !de_o); // R8

    AST_PAD_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !pad_en |=> (!hsync_o && !vsync_o && !de_o)); // R9

    AST_FLAG_FOLLOWS_BLANK: assert property (@(posedge clk) disable iff (rst)
        hblank_o |-> hb_flag_o); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hb_flag_o && !flag_clr_h) |=> hb_flag_o); // R10
endmodule

bind disp_timing_gen dtg_checker u_dtg_checker (
    .clk(clk), .rst(rst), .pad_en(pad_en), .oe_de(oe_de),
    .flag_clr_h(flag_clr_h), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
    .pix_x_o(pix_x_o), .line_y_o(line_y_o), .hb_flag_o(hb_flag_o)
);

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [10:0] h_total, v_total, h_active, v_active;
    logic [7:0]  h_act_ofs, v_act_ofs, h_de_ofs, v_de_ofs;
    logic [7:0]  hs_ofs, hs_len, vs_ofs, vs_len;
    logic pol_hs, pol_vs, pol_de, oe_hs, oe_vs, oe_de, pad_en, clk_pol;
    logic irq_en_h, irq_en_v, flag_clr_h, flag_clr_v;

    logic pclk_o, hsync_o, vsync_o, de_o, hblank_o, vblank_o;
    logic [10:0] pix_x_o, line_y_o;
    logic hb_flag_o, vb_flag_o, irq_o;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst(rst),
        .cfg_h_total(h_total), .cfg_v_total(v_total),
        .cfg_h_active(h_active), .cfg_v_active(v_active),
        .cfg_h_act_ofs(h_act_ofs), .cfg_v_act_ofs(v_act_ofs),
        .cfg_h_de_ofs(h_de_ofs), .cfg_v_de_ofs(v_de_ofs),
        .cfg_hs_ofs(hs_ofs), .cfg_hs_len(hs_len),
        .cfg_vs_ofs(vs_ofs), .cfg_vs_len(vs_len),
        .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
        .oe_hs(oe_hs), .oe_vs(oe_vs), .oe_de(oe_de),
        .pad_en(pad_en), .clk_pol(clk_pol),
        .irq_en_h(irq_en_h), .irq_en_v(irq_en_v),
        .flag_clr_h(flag_clr_h), .flag_clr_v(flag_clr_v),
        .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .hblank_o(hblank_o), .vblank_o(vblank_o),
        .pix_x_o(pix_x_o), .line_y_o(line_y_o),
        .hb_flag_o(hb_flag_o), .vb_flag_o(vb_flag_o), .irq_o(irq_o)
    );

    typedef struct {
        int ht, vt, ha, va, hao, vao, hdo, vdo, hso, hsl, vso, vsl;
    } mcfg_t;

    typedef struct {
        bit hs, vs, de, hb, vb, hf, vf, irq;
        int x, y;
    } exp_t;

    exp_t  sb_q[$];
    mcfg_t mc;
    int    mh, mv;
    bit    mhf, mvf;
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string phase = "R2 base";

    function automatic mcfg_t live_cfg();
        mcfg_t c;
        c.ht = h_total;   c.vt = v_total;  c.ha = h_active; c.va = v_active;
        c.hao = h_act_ofs; c.vao = v_act_ofs; c.hdo = h_de_ofs; c.vdo = v_de_ofs;
        c.hso = hs_ofs;   c.hsl = hs_len;  c.vso = vs_ofs;  c.vsl = vs_len;
        return c;
    endfunction

    function automatic bit win(int p, int s, int l);
        return (p >= s) && (p < s + l);
    endfunction

    function automatic bit pin(bit raw, bit pol, bit oe);
        return pad_en & oe & (pol ? raw : !raw);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s (%s) at cycle %0d: actual=%0d expected=%0d",
                     tag, what, phase, cyc, act, exp);
        end
    endtask

    // Reference model: expectation for the position registered at this edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mh = 0; mv = 0; mhf = 0; mvf = 0;
            mc = live_cfg();
            sb_q.delete();
        end else begin
            exp_t e;
            bit last;
            e.hb = !win(mh, mc.hao, mc.ha);
            e.vb = !win(mv, mc.vao, mc.va);
            e.x  = (!e.hb && !e.vb) ? mh - mc.hao : 0;
            e.y  = (!e.hb && !e.vb) ? mv - mc.vao : 0;
            e.hs = pin(win(mh, mc.hso, (mc.hsl == 0) ? 1 : mc.hsl), pol_hs, oe_hs);
            e.vs = pin(win(mv, mc.vso, (mc.vsl == 0) ? 1 : mc.vsl), pol_vs, oe_vs);
            e.de = pin(win(mh, mc.hdo, mc.ha) && win(mv, mc.vdo, mc.va), pol_de, oe_de);
            mhf  = (mhf & !flag_clr_h) | e.hb;
            mvf  = (mvf & !flag_clr_v) | e.vb;
            e.hf = mhf; e.vf = mvf;
            e.irq = (mhf & irq_en_h) | (mvf & irq_en_v);
            sb_q.push_back(e);
            last = (mh >= mc.ht - 1) && (mv >= mc.vt - 1);
            if (mh >= mc.ht - 1) begin
                mh = 0;
                mv = (mv >= mc.vt - 1) ? 0 : mv + 1;
            end else begin
                mh++;
            end
            if (last) mc = live_cfg();
        end
    end

    // Monitor: compare settled outputs at the falling edge
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R2", "pix_x", pix_x_o, e.x);
            chk("R2", "line_y", line_y_o, e.y);
            chk("R3", "hblank", hblank_o, e.hb);
            chk("R3", "vblank", vblank_o, e.vb);
            chk("R4", "hsync", hsync_o, e.hs);
            chk("R5", "vsync", vsync_o, e.vs);
            chk("R6", "de", de_o, e.de);
            chk("R10", "hb_flag", hb_flag_o, e.hf);
            chk("R10", "vb_flag", vb_flag_o, e.vf);
            chk("R10", "irq", irq_o, e.irq);
            chk("R11", "pclk_low_phase", pclk_o, pad_en & clk_pol);
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            #1;
            chk("R11", "pclk_high_phase", pclk_o, pad_en & !clk_pol);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d cycles", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        h_total = 24; v_total = 10; h_active = 12; v_active = 5;
        h_act_ofs = 6; v_act_ofs = 3; h_de_ofs = 5; v_de_ofs = 3;
        hs_ofs = 1; hs_len = 3; vs_ofs = 0; vs_len = 2;
        pol_hs = 1; pol_vs = 1; pol_de = 1;
        oe_hs = 1; oe_vs = 1; oe_de = 1; pad_en = 1; clk_pol = 0;
        irq_en_h = 0; irq_en_v = 0; flag_clr_h = 0; flag_clr_v = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "hsync in reset", hsync_o, 0);
        chk("R1", "vsync in reset", vsync_o, 0);
        chk("R1", "de in reset", de_o, 0);
        chk("R1", "hblank in reset", hblank_o, 0);
        chk("R1", "vblank in reset", vblank_o, 0);
        chk("R1", "pix_x in reset", pix_x_o, 0);
        chk("R1", "hb_flag in reset", hb_flag_o, 0);
        chk("R1", "irq in reset", irq_o, 0);
        #1 rst = 0;

        phase = "R2 base frames";
        step(500);

        phase = "R7 low-active strobes";
        pol_hs = 0; pol_vs = 0; pol_de = 0; clk_pol = 1;
        step(300);

        phase = "R12 mid-frame change";
        do @(negedge clk); while (!(mh == 10 && mv == 4));
        #1 h_active = 4;
        @(negedge clk);
        chk("R12", "hblank keeps old width", hblank_o, 0);
        chk("R12", "pix_x keeps old width", pix_x_o, 4);
        #1;
        step(300);

        phase = "R4 zero-length syncs";
        pol_hs = 1; pol_vs = 1; pol_de = 1;
        hs_ofs = 0; hs_len = 0; vs_ofs = 7; vs_len = 0;
        step(500);

        phase = "R8 disabled strobes";
        oe_hs = 0; oe_de = 0;
        step(250);
        oe_vs = 0; oe_hs = 1;
        step(250);
        oe_vs = 1; oe_de = 1;

        phase = "R10 flag clearing";
        h_total = 16; v_total = 8; h_active = 10; v_active = 4;
        h_act_ofs = 3; v_act_ofs = 2; h_de_ofs = 4; v_de_ofs = 3;
        hs_ofs = 14; hs_len = 2; vs_ofs = 6; vs_len = 2;
        irq_en_h = 1;
        for (int i = 0; i < 40; i++) begin
            step(5);
            flag_clr_h = 1; flag_clr_v = (i % 2 == 0);
            step(1);
            flag_clr_h = 0; flag_clr_v = 0;
            if (i == 20) begin irq_en_h = 0; irq_en_v = 1; end
        end

        phase = "R9 pads off";
        pad_en = 0;
        step(250);
        pad_en = 1; clk_pol = 0;
        step(50);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule